// File: doc/BRIEF.md
# Signed-Magnitude Subtractor

This combinational unit takes two N-bit operands in signed-magnitude form and returns their difference A - B in that same form. The top bit of each operand and of the result is the sign (1 means negative); the lower N-1 bits hold the absolute value. Inside, each operand is widened by one bit and turned into two's complement. A negative operand becomes the negation of its zero-extended magnitude, and a positive one is simply zero-extended. A ripple adder then forms A + NOT(B) + 1 on this form. The result is turned back into sign plus magnitude.

Because the internal datapath is one bit wider than the operands, the difference itself never wraps. A separate flag reports any result whose magnitude does not fit in N-1 bits. Both encodings of zero are accepted on the inputs, and a zero result always leaves the unit with a clear sign bit. The unit is meant to be placed inside a larger datapath that keeps numbers in signed-magnitude form but wants to reuse an ordinary binary adder.

Top module: `sm_sub`

## Requirements
- R1: When A - B is positive and fits, `diff_o` bit N-1 is 0 and bits N-2..0 equal A - B.
- R2: When A - B is negative and fits, `diff_o` bit N-1 is 1 and bits N-2..0 equal B - A.
- R3: An operand with magnitude 0 and sign 1 (minus zero) gives exactly the same outputs as the same operand with sign 0.
- R4: When the difference is zero, `diff_o` is all zeros, including the sign bit.
- R5: `ovf_o` is 1 exactly when the magnitude of A - B exceeds 2^(N-1) - 1. While `ovf_o` is 1, `diff_o` carries no defined value.
- R6: `ovf_o` is never 1 when the operand signs are equal or when either magnitude is zero.
- R7: Differences at the edge of the range (magnitude exactly 2^(N-1) - 1) are returned without overflow.
- R8: Subtracting a negative operand adds its magnitude (for example, -3 - (-6) gives +3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Minuend: bit N-1 is the sign, bits N-2..0 the magnitude |
| b_i | input | N | Subtrahend, same format |
| diff_o | output | N | A - B in signed-magnitude form |
| ovf_o | output | 1 | Result magnitude does not fit in N-1 bits |

## Verification
The hardest situations are the ones at the format boundaries. These are minus-zero operands, a zero result reached from opposite sign bits, and differences that land exactly on, or one past, the largest magnitude. Random stimulus rarely hits all of them. The stimulus therefore sweeps every pair of operands for the default width, so each zero encoding, each boundary magnitude and each sign combination is applied against an arithmetic model. Directed cases before the sweep name these corners explicitly.

// File: rtl/sm_sub_pkg.sv
package sm_sub_pkg;
    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } sgn_e;
endpackage

// File: rtl/sm_to_tc.sv
module sm_to_tc #(
    parameter int W = 8
) (
    input  logic [W-1:0] sm_i,
    output logic [W:0]   tc_o
);
    import sm_sub_pkg::*;

    logic [W:0] mag_ext_d;
    logic [W:0] tc_d;

    always_comb begin
        mag_ext_d = {2'b00, sm_i[W-2:0]};
        if (sgn_e'(sm_i[W-1]) == SGN_NEG) begin
            tc_d = ~mag_ext_d + 1'b1;
        end else begin
            tc_d = mag_ext_d;
        end
        tc_o = tc_d;
    end

    // R3: a zero magnitude maps to zero whatever the sign bit
    always_comb begin
        if (sm_i[W-2:0] == '0) begin
            p_zero_maps_zero_r3: assert (tc_o == '0);
        end
    end

    // R1: a nonzero operand keeps its sign in two's complement form
    always_comb begin
        if (sm_i[W-2:0] != '0) begin
            p_sign_kept_r1: assert (tc_o[W] == sm_i[W-1]);
        end
    end
endmodule

// File: rtl/tc_addsub.sv
module tc_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] b_x;
    logic [W-1:0] carry;

    assign b_x      = b_i ^ {W{sub_i}};
    assign carry[0] = sub_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s_o[i] = a_i[i] ^ b_x[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a_i[i] & b_x[i]) | (carry[i] & (a_i[i] ^ b_x[i]));
        end
    end

    // R1: the sum, modulo 2^W, inverts the requested operation
    always_comb begin
        if (sub_i) begin
            p_sub_inverse_r1: assert (W'(s_o + b_i) == a_i);
        end else begin
            p_add_inverse_r1: assert (W'(s_o - b_i) == a_i);
        end
    end
endmodule

// File: rtl/tc_to_sm.sv
module tc_to_sm #(
    parameter int W = 8
) (
    input  logic [W:0]   tc_i,
    output logic         sign_o,
    output logic [W-2:0] mag_o,
    output logic         ovf_o
);
    logic [W:0] abs_d;

    always_comb begin
        abs_d  = tc_i[W] ? (~tc_i + 1'b1) : tc_i;
        ovf_o  = |abs_d[W:W-1];
        sign_o = tc_i[W];
        mag_o  = abs_d[W-2:0];
    end

    // R4: a zero magnitude never leaves with the sign set
    always_comb begin
        if (!ovf_o && mag_o == '0) begin
            p_zero_positive_r4: assert (sign_o == 1'b0);
        end
    end

    // R5: without overflow the sign and magnitude rebuild the wide value
    always_comb begin
        if (!ovf_o) begin
            p_roundtrip_r5: assert ((sign_o ? (W+1)'(-{2'b00, mag_o}) : {2'b00, mag_o}) == tc_i);
        end
    end
endmodule

// File: rtl/sm_sub.sv
module sm_sub #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] diff_o,
    output logic         ovf_o
);
    localparam int WIDE = N + 1;

    typedef struct packed {
        logic         sign;
        logic [N-2:0] mag;
        logic         ovf;
    } res_t;

    logic [WIDE-1:0] a_tc;
    logic [WIDE-1:0] b_tc;
    logic [WIDE-1:0] d_tc;
    logic            r_sign;
    logic [N-2:0]    r_mag;
    logic            r_ovf;
    res_t            res_d;

    sm_to_tc #(.W(N)) u_cvt_a (.sm_i(a_i), .tc_o(a_tc));
    sm_to_tc #(.W(N)) u_cvt_b (.sm_i(b_i), .tc_o(b_tc));

    tc_addsub #(.W(WIDE)) u_core (
        .a_i  (a_tc),
        .b_i  (b_tc),
        .sub_i(1'b1),
        .s_o  (d_tc)
    );

    tc_to_sm #(.W(N)) u_cvt_d (
        .tc_i  (d_tc),
        .sign_o(r_sign),
        .mag_o (r_mag),
        .ovf_o (r_ovf)
    );

    always_comb begin
        res_d.sign = r_sign;
        res_d.mag  = r_mag;
        res_d.ovf  = r_ovf;
        diff_o     = {res_d.sign, res_d.mag};
        ovf_o      = res_d.ovf;
    end

    // R6: overflow needs two nonzero operands with opposite sign bits
    always_comb begin
        if (ovf_o) begin
            p_no_overflow_r6: assert ((a_i[N-2:0] != '0) && (b_i[N-2:0] != '0)
                                      && (a_i[N-1] != b_i[N-1]));
        end
    end
endmodule

// File: tb/sm_sub_test.sv
module sm_sub_test;
    localparam int N    = 8;
    localparam int MAXM = (1 << (N - 1)) - 1;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] exp_d;
        logic         exp_ovf;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] diff;
    logic         ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    item_t q[$];

    always #2.5 clk = ~clk;

    sm_sub #(.N(N)) uut (.a_i(a), .b_i(b), .diff_o(diff), .ovf_o(ovf));

    function automatic int smval(logic [N-1:0] x);
        int m;
        m = int'(x[N-2:0]);
        return x[N-1] ? -m : m;
    endfunction

    task automatic drive(input logic [N-1:0] va, input logic [N-1:0] vb, input string tag);
        item_t it;
        int d;
        int m;
        @(posedge clk);
        {a, b} = {va, vb};
        d = smval(va) - smval(vb);
        m = (d < 0) ? -d : d;
        it.a       = va;
        it.b       = vb;
        it.exp_ovf = (m > MAXM);
        it.exp_d   = {(d < 0), m[N-2:0]};
        if (tag != "") it.tag = tag;
        else if (it.exp_ovf) it.tag = "R5";
        else if (d == 0) it.tag = "R4";
        else if (d < 0) it.tag = "R2";
        else it.tag = "R1";
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (ovf !== it.exp_ovf) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h ovf got %b exp %b", it.tag, it.a, it.b, ovf, it.exp_ovf);
            end else if (!it.exp_ovf && diff !== it.exp_d) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h diff got %h exp %h", it.tag, it.a, it.b, diff, it.exp_d);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        {a, b} = '0;
        drive(8'h00, 8'h00, "R4");   // idle state: 0 - 0
        drive(8'h09, 8'h0E, "R2");   // 9 - 14 = -5
        drive(8'h0D, 8'h06, "R1");   // 13 - 6 = 7
        drive(8'h83, 8'h86, "R8");   // -3 - (-6) = +3
        drive(8'h80, 8'h05, "R3");   // -0 - 5 = -5
        drive(8'h00, 8'h05, "R3");   // +0 - 5 = -5
        drive(8'h05, 8'h80, "R3");   // 5 - (-0) = 5
        drive(8'h80, 8'h00, "R4");   // -0 - +0 = +0
        drive(8'h85, 8'h85, "R4");   // -5 - (-5) = +0
        drive(8'h7F, 8'h80, "R7");   // max - (-0)
        drive(8'h00, 8'h7F, "R7");   // 0 - max = -max
        drive(8'h7E, 8'h81, "R7");   // 126 + 1 = 127
        drive(8'h7F, 8'h81, "R5");   // 128 overflows
        drive(8'hFF, 8'h7F, "R5");   // -254 overflows
        drive(8'hFF, 8'hFF, "R6");   // same sign, largest magnitudes
        drive(8'h7F, 8'h00, "R6");   // zero operand
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                drive(i[N-1:0], j[N-1:0], "");
            end
        end
        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout exp completion");
        finish_run();
    end
endmodule